// File: doc/BRIEF.md
# Seven-Operand Carry-Save Reduction Row

This block collapses seven equally wide unsigned operand words into two words, a sum word and a carry word. Added together with the carry word shifted up by one place, they give the arithmetic total of all seven operands. It is the wide reduction step in front of a final carry-propagate adder, for example after partial-product generation in a multiplier or in a multi-input accumulator. It has no clock and no state.

Each bit position holds one compressor cell. The cell counts the operand bits in its column with a small full-adder tree. The two upper bits of that count leave the cell as carry-outs. The first goes to the column one place higher and the second to the column two places higher. Both arrive there as weight-zero carry-ins. The low bit of the count is added to the two incoming carries with one full adder, and that adder drives the cell's sum and carry outputs. The carry-outs are taken from the column's own operand bits only, so no carry travels along the row, and the delay does not depend on the width.

Three padding columns above the operand width absorb the carries that leave the top of the row, so both results are WIDTH+3 bits wide. A parameter selects a six-operand version, which narrows the operand bus and the counting tree.

Top module: `csa_row72`

## Requirements
- R1: `sum_o + 2*carry_o` equals the sum of all OPS operands, where operand k occupies `opnd_i[k*WIDTH +: WIDTH]` and both outputs are WIDTH+3 bits wide.
- R2: For column i, c_i is the number of ones at bit i across the OPS operands, and c_i is 0 for i >= WIDTH.
- R3: Column i receives two carries of weight 0: bit 1 of c_(i-1) and bit 2 of c_(i-2). Either carry is 0 where that column does not exist.
- R4: Let L_i be bit 0 of c_i plus the two carries of R3. Then `sum_o[i]` is bit 0 of L_i and `carry_o[i]` is bit 1 of L_i.
- R5: The carry-ins of column 0 are zero, so `carry_o[0]` is always 0.
- R6: The top output bits `sum_o[WIDTH+2]` and `carry_o[WIDTH+2]` are always 0, even with every operand bit set.
- R7: With OPS = 6 the operand bus is 6*WIDTH bits wide, and R1 to R6 hold over six operands.
- R8: The outputs are a purely combinational function of the operands. The reduction takes no clock cycle, and all-zero operands give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | OPS*WIDTH | Operand words, operand k at bits k*WIDTH upward |
| sum_o | output | WIDTH+3 | Sum word of the redundant result |
| carry_o | output | WIDTH+3 | Carry word, to be added shifted up by one bit |

## Verification
All-zero operands confirm the idle result. All-ones operands drive every column count to its maximum, so both carry paths are active in every column and a carry reaches the padding columns. Patterns with a single operand set, and alternating stripes, separate a carry that lands one column up from one that lands two columns up. Seeded random words are checked bit by bit against the column rule and against the arithmetic total, on both the seven-operand and the six-operand instance.

// File: rtl/csa_row72.sv
`timescale 1ns/1ps
module csa_row72 #(
  parameter int WIDTH = 16,
  parameter int OPS   = 7
) (
  input  logic [OPS*WIDTH-1:0] opnd_i,
  output logic [WIDTH+2:0]     sum_o,
  output logic [WIDTH+2:0]     carry_o
);
  localparam int OUT_W = WIDTH + 3;

  if (OPS < 6 || OPS > 7) begin : g_bad_ops
    $error("csa_row72: OPS must be 6 or 7");
  end

  logic [WIDTH-1:0] co_near;
  logic [WIDTH-1:0] co_far;

  for (genvar i = 0; i < OUT_W; i++) begin : g_col
    logic cin_a, cin_b;

    if (i >= 1 && i - 1 < WIDTH) begin : g_cina
      assign cin_a = co_near[i-1];
    end else begin : g_cina0
      assign cin_a = 1'b0;
    end

    if (i >= 2 && i - 2 < WIDTH) begin : g_cinb
      assign cin_b = co_far[i-2];
    end else begin : g_cinb0
      assign cin_b = 1'b0;
    end

    if (i < WIDTH) begin : g_live
      logic [6:0] x;
      logic s1, c1, s2, c2, d0, c3;

      for (genvar k = 0; k < 7; k++) begin : g_tap
        if (k < OPS) begin : g_used
          assign x[k] = opnd_i[k*WIDTH + i];
        end else begin : g_tied
          assign x[k] = 1'b0;
        end
      end

      assign s1 = x[0] ^ x[1] ^ x[2];
      assign c1 = (x[0] & x[1]) | (x[2] & (x[0] ^ x[1]));
      assign s2 = x[3] ^ x[4] ^ x[5];
      assign c2 = (x[3] & x[4]) | (x[5] & (x[3] ^ x[4]));

      if (OPS == 7) begin : g_fa3
        assign d0 = s1 ^ s2 ^ x[6];
        assign c3 = (s1 & s2) | (x[6] & (s1 ^ s2));
      end else begin : g_ha3
        assign d0 = s1 ^ s2;
        assign c3 = s1 & s2;
      end

      assign co_near[i] = c1 ^ c2 ^ c3;
      assign co_far[i]  = (c1 & c2) | (c3 & (c1 ^ c2));

      assign sum_o[i]   = d0 ^ cin_a ^ cin_b;
      assign carry_o[i] = (d0 & cin_a) | (cin_b & (d0 ^ cin_a));

      always_comb begin
        if (!$isunknown(x)) begin
          AST_COUT_FROM_DATA: assert ({co_far[i], co_near[i]} == 2'(3'($countones(x)) >> 1))
            else $error("carry-outs of column %0d disagree with its bit count", i); // R2
        end
        if (!$isunknown({x, cin_a, cin_b})) begin
          AST_LOCAL_SUM: assert ({carry_o[i], sum_o[i]} ==
                                 2'(32'($countones(x) & 1) + 32'(cin_a) + 32'(cin_b)))
            else $error("local outputs of column %0d are wrong", i); // R4
        end
      end
    end else begin : g_pad
      assign sum_o[i]   = cin_a ^ cin_b;
      assign carry_o[i] = cin_a & cin_b;
    end
  end

  logic [OUT_W:0] chk_total;
  always_comb begin
    chk_total = '0;
    for (int k = 0; k < OPS; k++) begin
      chk_total = chk_total + (OUT_W+1)'(opnd_i[k*WIDTH +: WIDTH]);
    end
  end

  always_comb begin
    if (!$isunknown(opnd_i)) begin
      AST_ROW_TOTAL: assert (({1'b0, sum_o} + {carry_o, 1'b0}) == chk_total)
        else $error("row result does not add up to the operand total"); // R1
      AST_CARRY_LSB: assert (carry_o[0] == 1'b0)
        else $error("carry word bit 0 is set"); // R5
      AST_TOP_CLEAR: assert (sum_o[OUT_W-1] == 1'b0 && carry_o[OUT_W-1] == 1'b0)
        else $error("top output bit is set"); // R6
    end
  end
endmodule

// File: tb/csa_row72_tb.sv
`timescale 1ns/1ps
module csa_row72_tb_top;
  localparam int W  = 16;
  localparam int OW = W + 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [7*W-1:0] opnd7;
  logic [6*W-1:0] opnd6;
  logic [OW-1:0]  sum7, carry7, sum6, carry6;

  csa_row72 #(.WIDTH(W), .OPS(7)) dut_i   (.opnd_i(opnd7), .sum_o(sum7), .carry_o(carry7));
  csa_row72 #(.WIDTH(W), .OPS(6)) dut6_i  (.opnd_i(opnd6), .sum_o(sum6), .carry_o(carry6));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // R2: column counts; R3: carries from one and two columns below; R4: local bits
  function automatic logic [OW-1:0] exp_word(input logic [7*W-1:0] v, input int nops,
                                             input bit want_carry);
    int cnt [OW];
    logic [OW-1:0] res;
    for (int i = 0; i < OW; i++) begin
      cnt[i] = 0;
      if (i < W) for (int k = 0; k < nops; k++) cnt[i] += int'(v[k*W + i]);
    end
    for (int i = 0; i < OW; i++) begin
      int loc;
      loc = cnt[i] & 1;
      if (i >= 1) loc += (cnt[i-1] >> 1) & 1;
      if (i >= 2) loc += (cnt[i-2] >> 2) & 1;
      res[i] = want_carry ? loc[1] : loc[0];
    end
    return res;
  endfunction

  function automatic longint exp_total(input logic [7*W-1:0] v, input int nops);
    longint t = 0;
    for (int k = 0; k < nops; k++) t += longint'(v[k*W +: W]);
    return t;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7*W-1:0] v);
    @(posedge clk);
    #1;
    opnd7 = v;
    opnd6 = v[6*W-1:0];
    #2;
    check("R4", "sum7 bits (R2/R3)",   longint'(sum7),   longint'(exp_word(v, 7, 1'b0)));
    check("R4", "carry7 bits (R2/R3)", longint'(carry7), longint'(exp_word(v, 7, 1'b1)));
    check("R1", "total7", longint'(sum7) + 2*longint'(carry7), exp_total(v, 7));
    check("R5", "carry7 lsb", longint'(carry7[0]), 0);
    check("R6", "top bits", longint'({sum7[OW-1], carry7[OW-1]}), 0);
    check("R7", "sum6",   longint'(sum6),   longint'(exp_word(v, 6, 1'b0)));
    check("R7", "carry6", longint'(carry6), longint'(exp_word(v, 6, 1'b1)));
    check("R7", "total6", longint'(sum6) + 2*longint'(carry6), exp_total(v, 6));
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    logic [7*W-1:0] v;
    opnd7 = '0;
    opnd6 = '0;
    void'($urandom(32'h1357_9bdf));
    #3;
    check("R8", "idle sum7",   longint'(sum7),   0);
    check("R8", "idle carry7", longint'(carry7), 0);
    check("R8", "idle sum6",   longint'(sum6),   0);

    apply('1);
    check("R1", "all-ones total7", longint'(sum7) + 2*longint'(carry7), 7*longint'(16'hFFFF));
    apply('0);
    v = '0; v[W-1:0] = '1; apply(v);
    v = '0; v[6*W +: W] = '1; apply(v);
    for (int k = 0; k < 7; k++) v[k*W +: W] = (k % 2 == 0) ? 16'hAAAA : 16'h5555;
    apply(v);
    for (int k = 0; k < 7; k++) v[k*W +: W] = 16'h8000;
    apply(v);
    for (int k = 0; k < 7; k++) v[k*W +: W] = 16'h0001 << k;
    apply(v);

    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 7; k++) v[k*W +: W] = 16'($urandom);
      if (n % 5 == 0) v[(n % 7)*W +: W] = '1;
      apply(v);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule